// File: doc/BRIEF.md
# DMA Register and Interrupt Unit

This block is the control front end of a multi-channel DMA controller. A simple word-addressed bus with separate read and write strobes reaches a bank of per-channel words and a handful of global words. Each channel has five words: source address, destination address, link pointer, control and configuration. A global configuration word holds the controller-wide enable. The transfer engines live outside this block. They read the channel words from flat output buses and report back through three per-channel strobes: terminal count reached, error seen, and drop enable.

The unit keeps one raw terminal-count bit and one raw error bit per channel. There are no separate mask registers. Bit 15 of a channel's configuration word enables its terminal-count interrupt, and bit 14 enables its error interrupt. Masked and raw views can be read. Raw bits are cleared by writing ones. A single level interrupt output reflects any masked bit that is set. The unit also reports which channels are enabled and returns eight fixed identification bytes.

Byte offsets divided by four give the word addresses used here. Channel words are at 0x40 + 8*channel + k. Global words are at 0x00 to 0x0F. Identification words are at 0x3F8 to 0x3FF. Read data is registered, so it appears on the cycle after the read strobe.

Top module: `dmac_regs`

## Requirements
- R1: After reset, all channel words, the global configuration, the raw interrupt bits, `rdata`, `irq`, `ch_active` and `ctrl_en` are zero.
- R2: For channel c < NUM_CH, word address 0x40+8*c+k, with k = 0 (source), 1 (destination), 2 (link), 3 (control) and 4 (configuration), stores the written value and reads it back. The configuration word also appears on `ch_cfg[32*c +: 32]`. Words with k = 5..7 read as zero.
- R3: A channel word access whose channel index, address bits [5:3], is at or above NUM_CH reads as zero. Such a write changes no stored word.
- R4: A pulse on `tc_set[c]` or `err_set[c]` sets raw bit c. Raw terminal-count bits read at word 5 and raw error bits at word 6.
- R5: Word 1 returns the raw TC bits ANDed with configuration bit 15 of each channel. Word 3 returns the raw error bits ANDed with configuration bit 14. Word 0 returns the OR of the two.
- R6: A write to word 2 clears each raw TC bit whose data bit is 1, and a write to word 4 does the same for the error bits. Bits written 0 are kept. A set strobe in the same cycle wins over the clear.
- R7: `irq` is 1 exactly when word 0 would read nonzero, and it follows the raw state without added delay.
- R8: Word 7 and `ch_active` hold bit c = configuration bit 0 of channel c. `en_clr[c]` clears that bit and wins over a same-cycle bus write.
- R9: Word 12 is the global configuration, readable and writable. Its bit 0 drives `ctrl_en`.
- R10: Words 0x3F8..0x3FF return one identification byte each, in order: first byte, 0x10, 0x04, 0x0A, 0x0D, 0xF0, 0x05, 0xB1. The first byte is 0x81 when NUM_CH is 2 and 0x80 otherwise.
- R11: `rdata` changes only on the cycle after `rd_en` and holds otherwise. Unmapped words and the clear words read as zero. Writes to read-only words have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe |
| addr | input | 10 | Word address |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Registered read data |
| tc_set | input | NUM_CH | Per-channel terminal-count event |
| err_set | input | NUM_CH | Per-channel error event |
| en_clr | input | NUM_CH | Per-channel enable drop from the engine |
| irq | output | 1 | Combined interrupt |
| ctrl_en | output | 1 | Global controller enable |
| ch_active | output | NUM_CH | Per-channel enable bits |
| ch_src | output | 32*NUM_CH | Source words, flattened |
| ch_dst | output | 32*NUM_CH | Destination words, flattened |
| ch_link | output | 32*NUM_CH | Link words, flattened |
| ch_ctrl | output | 32*NUM_CH | Control words, flattened |
| ch_cfg | output | 32*NUM_CH | Configuration words, flattened |

## Verification
The bench builds the unit with four channels, so channel indices 4 to 7 can test out-of-range access. It drives distinct values into several channels, which would expose aliasing between channel or word indices. The interrupt logic is tried with mixed event patterns: terminal-count events on some channels, error events on others, and mask bits set on only part of them. This separates the raw status views from the masked ones and the TC path from the error path. Same-cycle collisions, set against clear and engine disable against bus write, settle which side has priority.

// File: rtl/dmac_regs_pkg.sv
package dmac_regs_pkg;

    localparam int DW       = 32;
    localparam int WORD_AW  = 10;

    localparam logic [3:0] GW_STATUS  = 4'd0;
    localparam logic [3:0] GW_TC_MSK  = 4'd1;
    localparam logic [3:0] GW_TC_CLR  = 4'd2;
    localparam logic [3:0] GW_ER_MSK  = 4'd3;
    localparam logic [3:0] GW_ER_CLR  = 4'd4;
    localparam logic [3:0] GW_TC_RAW  = 4'd5;
    localparam logic [3:0] GW_ER_RAW  = 4'd6;
    localparam logic [3:0] GW_ACTIVE  = 4'd7;
    localparam logic [3:0] GW_GCFG    = 4'd12;

    localparam int CFG_TCIE = 15;
    localparam int CFG_ERIE = 14;
    localparam int CFG_ON   = 0;

    typedef enum logic [2:0] {
        CW_SRC  = 3'd0,
        CW_DST  = 3'd1,
        CW_LINK = 3'd2,
        CW_CTRL = 3'd3,
        CW_CFG  = 3'd4
    } chan_word_e;

    typedef struct packed {
        logic [DW-1:0] src;
        logic [DW-1:0] dst;
        logic [DW-1:0] link;
        logic [DW-1:0] ctrl;
        logic [DW-1:0] cfg;
    } chan_regs_t;

    function automatic logic [7:0] id_byte(input logic [2:0] idx, input int nch);
        case (idx)
            3'd0:    id_byte = (nch == 2) ? 8'h81 : 8'h80;
            3'd1:    id_byte = 8'h10;
            3'd2:    id_byte = 8'h04;
            3'd3:    id_byte = 8'h0A;
            3'd4:    id_byte = 8'h0D;
            3'd5:    id_byte = 8'hF0;
            3'd6:    id_byte = 8'h05;
            default: id_byte = 8'hB1;
        endcase
    endfunction

endpackage

// File: rtl/dmac_chan_bank.sv
module dmac_chan_bank
    import dmac_regs_pkg::*;
#(
    parameter int NUM_CH = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic [WORD_AW-1:0] addr,
    input  logic [DW-1:0]      wdata,
    input  logic [NUM_CH-1:0]  en_clr,
    output chan_regs_t         regs_o [NUM_CH]
);

    localparam logic [WORD_AW-7:0] CH_REGION = (WORD_AW-6)'(1);

    logic in_chan;
    assign in_chan = (addr[WORD_AW-1:6] == CH_REGION);

    // Only channels below NUM_CH exist, so writes to higher indices land nowhere.
    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        chan_regs_t r_d, r_q;
        logic       hit;

        assign hit = wr_en && in_chan && (addr[5:3] == 3'(c));

        always_comb begin
            r_d = r_q;
            if (hit) begin
                case (chan_word_e'(addr[2:0]))
                    CW_SRC:  r_d.src  = wdata;
                    CW_DST:  r_d.dst  = wdata;
                    CW_LINK: r_d.link = wdata;
                    CW_CTRL: r_d.ctrl = wdata;
                    CW_CFG:  r_d.cfg  = wdata;
                    default: ;
                endcase
            end
            // Engine drop of the enable bit has the last word.
            if (en_clr[c]) begin
                r_d.cfg[CFG_ON] = 1'b0;
            end
        end

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                r_q <= '0;
            end else begin
                r_q <= r_d;
            end
        end

        assign regs_o[c] = r_q;
    end

endmodule

// File: rtl/dmac_irq_core.sv
module dmac_irq_core #(
    parameter int NUM_CH = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tc_clr_we,
    input  logic              er_clr_we,
    input  logic [NUM_CH-1:0] clr_bits,
    input  logic [NUM_CH-1:0] tc_set,
    input  logic [NUM_CH-1:0] err_set,
    input  logic [NUM_CH-1:0] tc_mask,
    input  logic [NUM_CH-1:0] er_mask,
    output logic [NUM_CH-1:0] tc_raw,
    output logic [NUM_CH-1:0] er_raw,
    output logic [NUM_CH-1:0] tc_msk,
    output logic [NUM_CH-1:0] er_msk,
    output logic              irq
);

    typedef struct packed {
        logic [NUM_CH-1:0] tc;
        logic [NUM_CH-1:0] er;
    } irq_st_t;

    irq_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (tc_clr_we) begin
            st_d.tc = st_d.tc & ~clr_bits;
        end
        if (er_clr_we) begin
            st_d.er = st_d.er & ~clr_bits;
        end
        // New events are applied after the clear so none is lost.
        st_d.tc = st_d.tc | tc_set;
        st_d.er = st_d.er | err_set;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign tc_raw = st_q.tc;
    assign er_raw = st_q.er;
    assign tc_msk = st_q.tc & tc_mask;
    assign er_msk = st_q.er & er_mask;
    assign irq    = |{tc_msk, er_msk};

endmodule

// File: rtl/dmac_rd_mux.sv
module dmac_rd_mux
    import dmac_regs_pkg::*;
#(
    parameter int NUM_CH = 8
) (
    input  logic [WORD_AW-1:0] addr,
    input  chan_regs_t         regs [NUM_CH],
    input  logic [NUM_CH-1:0]  tc_raw,
    input  logic [NUM_CH-1:0]  er_raw,
    input  logic [NUM_CH-1:0]  tc_msk,
    input  logic [NUM_CH-1:0]  er_msk,
    input  logic [NUM_CH-1:0]  active,
    input  logic [DW-1:0]      gcfg,
    output logic [DW-1:0]      rd_val
);

    localparam logic [WORD_AW-7:0] CH_REGION = (WORD_AW-6)'(1);
    localparam logic [WORD_AW-4:0] ID_REGION = '1;

    chan_regs_t sel;
    logic       sel_ok;

    always_comb begin
        sel    = '0;
        sel_ok = 1'b0;
        for (int c = 0; c < NUM_CH; c++) begin
            if (addr[5:3] == 3'(c)) begin
                sel    = regs[c];
                sel_ok = 1'b1;
            end
        end
    end

    always_comb begin
        rd_val = '0;
        if (addr[WORD_AW-1:6] == CH_REGION) begin
            if (sel_ok) begin
                case (chan_word_e'(addr[2:0]))
                    CW_SRC:  rd_val = sel.src;
                    CW_DST:  rd_val = sel.dst;
                    CW_LINK: rd_val = sel.link;
                    CW_CTRL: rd_val = sel.ctrl;
                    CW_CFG:  rd_val = sel.cfg;
                    default: rd_val = '0;
                endcase
            end
        end else if (addr[WORD_AW-1:3] == ID_REGION) begin
            rd_val = DW'(id_byte(addr[2:0], NUM_CH));
        end else if (addr[WORD_AW-1:4] == '0) begin
            case (addr[3:0])
                GW_STATUS: rd_val = DW'(tc_msk | er_msk);
                GW_TC_MSK: rd_val = DW'(tc_msk);
                GW_ER_MSK: rd_val = DW'(er_msk);
                GW_TC_RAW: rd_val = DW'(tc_raw);
                GW_ER_RAW: rd_val = DW'(er_raw);
                GW_ACTIVE: rd_val = DW'(active);
                GW_GCFG:   rd_val = gcfg;
                default:   rd_val = '0;
            endcase
        end
    end

endmodule

// File: rtl/dmac_regs.sv
module dmac_regs
    import dmac_regs_pkg::*;
#(
    parameter int NUM_CH = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_en,
    input  logic                 rd_en,
    input  logic [9:0]           addr,
    input  logic [31:0]          wdata,
    output logic [31:0]          rdata,
    input  logic [NUM_CH-1:0]    tc_set,
    input  logic [NUM_CH-1:0]    err_set,
    input  logic [NUM_CH-1:0]    en_clr,
    output logic                 irq,
    output logic                 ctrl_en,
    output logic [NUM_CH-1:0]    ch_active,
    output logic [32*NUM_CH-1:0] ch_src,
    output logic [32*NUM_CH-1:0] ch_dst,
    output logic [32*NUM_CH-1:0] ch_link,
    output logic [32*NUM_CH-1:0] ch_ctrl,
    output logic [32*NUM_CH-1:0] ch_cfg
);

    typedef struct packed {
        logic [DW-1:0] gcfg;
        logic [DW-1:0] rdata;
    } top_st_t;

    top_st_t           st_d, st_q;
    chan_regs_t        regs [NUM_CH];
    logic [NUM_CH-1:0] tc_mask, er_mask;
    logic [NUM_CH-1:0] tc_raw_w, er_raw_w, tc_msk_w, er_msk_w;
    logic [DW-1:0]     rd_val;
    logic              glob, tc_clr_we, er_clr_we;

    assign glob      = (addr[WORD_AW-1:4] == '0);
    assign tc_clr_we = wr_en && glob && (addr[3:0] == GW_TC_CLR);
    assign er_clr_we = wr_en && glob && (addr[3:0] == GW_ER_CLR);

    dmac_chan_bank #(.NUM_CH(NUM_CH)) u_bank (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (wr_en),
        .addr   (addr),
        .wdata  (wdata),
        .en_clr (en_clr),
        .regs_o (regs)
    );

    for (genvar c = 0; c < NUM_CH; c++) begin : g_out
        assign tc_mask[c]           = regs[c].cfg[CFG_TCIE];
        assign er_mask[c]           = regs[c].cfg[CFG_ERIE];
        assign ch_active[c]         = regs[c].cfg[CFG_ON];
        assign ch_src [32*c +: 32]  = regs[c].src;
        assign ch_dst [32*c +: 32]  = regs[c].dst;
        assign ch_link[32*c +: 32]  = regs[c].link;
        assign ch_ctrl[32*c +: 32]  = regs[c].ctrl;
        assign ch_cfg [32*c +: 32]  = regs[c].cfg;
    end

    dmac_irq_core #(.NUM_CH(NUM_CH)) u_irq (
        .clk       (clk),
        .rst_n     (rst_n),
        .tc_clr_we (tc_clr_we),
        .er_clr_we (er_clr_we),
        .clr_bits  (wdata[NUM_CH-1:0]),
        .tc_set    (tc_set),
        .err_set   (err_set),
        .tc_mask   (tc_mask),
        .er_mask   (er_mask),
        .tc_raw    (tc_raw_w),
        .er_raw    (er_raw_w),
        .tc_msk    (tc_msk_w),
        .er_msk    (er_msk_w),
        .irq       (irq)
    );

    dmac_rd_mux #(.NUM_CH(NUM_CH)) u_rd (
        .addr   (addr),
        .regs   (regs),
        .tc_raw (tc_raw_w),
        .er_raw (er_raw_w),
        .tc_msk (tc_msk_w),
        .er_msk (er_msk_w),
        .active (ch_active),
        .gcfg   (st_q.gcfg),
        .rd_val (rd_val)
    );

    always_comb begin
        st_d = st_q;
        if (wr_en && glob && (addr[3:0] == GW_GCFG)) begin
            st_d.gcfg = wdata;
        end
        if (rd_en) begin
            st_d.rdata = rd_val;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign rdata   = st_q.rdata;
    assign ctrl_en = st_q.gcfg[0];

endmodule

// File: rtl/dmac_regs_chk.sv
module dmac_regs_chk #(
    parameter int NUM_CH = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wr_en,
    input logic              rd_en,
    input logic [9:0]        addr,
    input logic [31:0]       wdata,
    input logic [31:0]       rdata,
    input logic [NUM_CH-1:0] tc_set,
    input logic [NUM_CH-1:0] err_set,
    input logic [NUM_CH-1:0] en_clr,
    input logic              irq,
    input logic [NUM_CH-1:0] ch_active,
    input logic [NUM_CH-1:0] tc_raw,
    input logic [NUM_CH-1:0] er_raw
);

    // R4
    tc_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tc_set != '0) |=> ((tc_raw & $past(tc_set)) == $past(tc_set)));

    // R4
    err_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (err_set != '0) |=> ((er_raw & $past(err_set)) == $past(err_set)));

    // R6
    tc_w1c_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == 10'd2 && tc_set == '0)
        |=> ((tc_raw & $past(wdata[NUM_CH-1:0])) == '0));

    // R7
    irq_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> ((tc_raw | er_raw) != '0));

    // R8
    en_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (en_clr != '0) |=> ((ch_active & $past(en_clr)) == '0));

    // R11
    rdata_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |=> $stable(rdata));

endmodule

bind dmac_regs dmac_regs_chk #(.NUM_CH(NUM_CH)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (wr_en),
    .rd_en     (rd_en),
    .addr      (addr),
    .wdata     (wdata),
    .rdata     (rdata),
    .tc_set    (tc_set),
    .err_set   (err_set),
    .en_clr    (en_clr),
    .irq       (irq),
    .ch_active (ch_active),
    .tc_raw    (tc_raw_w),
    .er_raw    (er_raw_w)
);

// File: tb/test_dmac_regs.sv
module test_dmac_regs;

    localparam int NCH = 4;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic           wr_en = 1'b0, rd_en = 1'b0;
    logic [9:0]     addr = '0;
    logic [31:0]    wdata = '0;
    logic [31:0]    rdata;
    logic [NCH-1:0] tc_set = '0, err_set = '0, en_clr = '0;
    logic           irq, ctrl_en;
    logic [NCH-1:0] ch_active;
    logic [32*NCH-1:0] ch_src, ch_dst, ch_link, ch_ctrl, ch_cfg;

    int n_cmp = 0;
    int n_bad = 0;

    always #5 clk = ~clk;

    dmac_regs #(.NUM_CH(NCH)) i_dmac_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
        .wdata(wdata), .rdata(rdata), .tc_set(tc_set), .err_set(err_set),
        .en_clr(en_clr), .irq(irq), .ctrl_en(ctrl_en), .ch_active(ch_active),
        .ch_src(ch_src), .ch_dst(ch_dst), .ch_link(ch_link), .ch_ctrl(ch_ctrl),
        .ch_cfg(ch_cfg)
    );

    // Behavioural reference model
    logic [31:0]    m_ch [NCH][5];
    logic [31:0]    m_g;
    logic [NCH-1:0] m_tc, m_er;
    logic [31:0]    m_rd;

    function automatic logic [NCH-1:0] m_mask(input int bitpos);
        logic [NCH-1:0] r;
        for (int c = 0; c < NCH; c++) r[c] = m_ch[c][bitpos / 32][bitpos % 32];
        return r;
    endfunction

    function automatic logic [NCH-1:0] m_bit(input int b);
        logic [NCH-1:0] r;
        for (int c = 0; c < NCH; c++) r[c] = m_ch[c][4][b];
        return r;
    endfunction

    function automatic logic [31:0] m_read(input logic [9:0] a);
        logic [NCH-1:0] tm, em;
        int ch, k;
        logic [7:0] ids [8];
        ids = '{8'h80, 8'h10, 8'h04, 8'h0A, 8'h0D, 8'hF0, 8'h05, 8'hB1};
        tm = m_tc & m_bit(15);
        em = m_er & m_bit(14);
        if (a >= 10'h40 && a < 10'h80) begin
            ch = (a - 10'h40) / 8;
            k  = (a - 10'h40) % 8;
            if (ch < NCH && k < 5) return m_ch[ch][k];
            return 32'd0;
        end
        if (a >= 10'h3F8) return {24'd0, ids[a - 10'h3F8]};
        case (a)
            10'd0:  return 32'(tm | em);
            10'd1:  return 32'(tm);
            10'd3:  return 32'(em);
            10'd5:  return 32'(m_tc);
            10'd6:  return 32'(m_er);
            10'd7:  return 32'(m_bit(0));
            10'd12: return m_g;
            default: return 32'd0;
        endcase
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            for (int c = 0; c < NCH; c++) for (int k = 0; k < 5; k++) m_ch[c][k] = '0;
            m_g = '0; m_tc = '0; m_er = '0; m_rd = '0;
        end else begin
            logic [NCH-1:0] ntc, ner;
            if (rd_en) m_rd = m_read(addr);
            ntc = m_tc; ner = m_er;
            if (wr_en && addr == 10'd2) ntc = ntc & ~wdata[NCH-1:0];
            if (wr_en && addr == 10'd4) ner = ner & ~wdata[NCH-1:0];
            ntc = ntc | tc_set; ner = ner | err_set;
            if (wr_en && addr >= 10'h40 && addr < 10'h80) begin
                int ch, k;
                ch = (addr - 10'h40) / 8;
                k  = (addr - 10'h40) % 8;
                if (ch < NCH && k < 5) m_ch[ch][k] = wdata;
            end
            if (wr_en && addr == 10'd12) m_g = wdata;
            for (int c = 0; c < NCH; c++) if (en_clr[c]) m_ch[c][4][0] = 1'b0;
            m_tc = ntc; m_er = ner;
        end
    end

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Clock-by-clock comparison against the model
    always @(negedge clk) begin
        if (rst_n) begin
            logic [NCH-1:0] tm, em;
            tm = m_tc & m_bit(15);
            em = m_er & m_bit(14);
            check("R11 rdata vs model", rdata, m_rd);
            check("R7 irq vs model", 32'(irq), 32'(|(tm | em)));
            check("R8 ch_active vs model", 32'(ch_active), 32'(m_bit(0)));
            check("R9 ctrl_en vs model", 32'(ctrl_en), 32'(m_g[0]));
            for (int c = 0; c < NCH; c++)
                check("R2 ch_cfg vs model", ch_cfg[32*c +: 32], m_ch[c][4]);
        end
    end

    task automatic wr(input logic [9:0] a, input logic [31:0] d);
        wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [9:0] a, input logic [31:0] exp, input string tag);
        rd_en = 1'b1; addr = a;
        @(negedge clk);
        rd_en = 1'b0;
        check(tag, rdata, exp);
    endtask

    task automatic pulse(input logic [NCH-1:0] t, input logic [NCH-1:0] e, input logic [NCH-1:0] x);
        tc_set = t; err_set = e; en_clr = x;
        @(negedge clk);
        tc_set = '0; err_set = '0; en_clr = '0;
    endtask

    initial begin
        #2000000;
        n_bad++;
        $display("FAIL watchdog expired");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1: reset state
        check("R1 irq after reset", 32'(irq), 0);
        check("R1 rdata after reset", rdata, 0);
        rd(10'd5, 0, "R1 raw tc zero");
        rd(10'd7, 0, "R1 active zero");
        rd(10'd12, 0, "R1 gcfg zero");
        rd(10'h44, 0, "R1 channel cfg zero");
        // R2: distinct values in several channels and words
        for (int c = 0; c < NCH; c++)
            for (int k = 0; k < 4; k++)
                wr(10'(10'h40 + 8*c + k), 32'hA000_0000 + 32'(c*16 + k));
        for (int c = 0; c < NCH; c++)
            for (int k = 0; k < 4; k++)
                rd(10'(10'h40 + 8*c + k), 32'hA000_0000 + 32'(c*16 + k), "R2 channel word readback");
        rd(10'h45, 0, "R2 word k=5 reads zero");
        rd(10'h5F, 0, "R2 word k=7 reads zero");
        // R3: out-of-range channel indices
        wr(10'h60, 32'hDEAD_BEEF);
        rd(10'h60, 0, "R3 channel 4 reads zero");
        wr(10'h7C, 32'hFFFF_FFFF);
        rd(10'h7C, 0, "R3 channel 7 cfg reads zero");
        rd(10'h40, 32'hA000_0000, "R3 channel 0 untouched");
        check("R3 channel 0 src port", ch_src[31:0], 32'hA000_0000);
        // R9: global configuration
        wr(10'd12, 32'h0000_0003);
        rd(10'd12, 32'h0000_0003, "R9 gcfg readback");
        check("R9 ctrl_en", 32'(ctrl_en), 1);
        // R5 masks: ch0 TC ie, ch1 err ie, ch2 both, ch3 none; all enabled
        wr(10'h44, 32'h0000_8001);
        wr(10'h4C, 32'h0000_4001);
        wr(10'h54, 32'h0000_C001);
        wr(10'h5C, 32'h0000_0001);
        rd(10'd7, 32'hF, "R8 all channels active");
        // R4: raw capture
        pulse(4'b1001, 4'b0000, 4'b0000);
        check("R7 irq from masked tc", 32'(irq), 1);
        rd(10'd5, 32'h9, "R4 raw tc");
        pulse(4'b0000, 4'b1010, 4'b0000);
        rd(10'd6, 32'hA, "R4 raw err");
        rd(10'd1, 32'h1, "R5 masked tc");
        rd(10'd3, 32'h2, "R5 masked err");
        rd(10'd0, 32'h3, "R5 combined status");
        // R6: write-one-to-clear
        wr(10'd2, 32'h1);
        rd(10'd5, 32'h8, "R6 tc bit0 cleared, bit3 kept");
        check("R7 irq stays from err", 32'(irq), 1);
        wr(10'd4, 32'h2);
        rd(10'd6, 32'h8, "R6 err bit1 cleared");
        check("R7 irq low, only unmasked bits", 32'(irq), 0);
        // R6: set wins over same-cycle clear
        tc_set = 4'b0100; wr(10'd2, 32'hF); tc_set = '0;
        rd(10'd5, 32'h4, "R6 set beats clear");
        check("R7 irq from ch2", 32'(irq), 1);
        // R11: writes to read-only words are ignored
        wr(10'd5, 32'h0);
        wr(10'd0, 32'hF);
        rd(10'd5, 32'h4, "R11 raw word not writable");
        wr(10'd2, 32'hF);
        wr(10'd4, 32'hF);
        check("R7 irq low after clear", 32'(irq), 0);
        // R8: engine disable wins over same-cycle write
        en_clr = 4'b0010; wr(10'h4C, 32'h0000_4001); en_clr = '0;
        rd(10'd7, 32'hD, "R8 en_clr beats write");
        pulse(4'b0000, 4'b0000, 4'b0001);
        rd(10'd7, 32'hC, "R8 en_clr ch0");
        rd(10'h44, 32'h0000_8000, "R8 cfg bit0 dropped only");
        // R10: identification
        rd(10'h3F8, 32'h80, "R10 id byte 0");
        rd(10'h3FB, 32'h0A, "R10 id byte 3");
        rd(10'h3FF, 32'hB1, "R10 id byte 7");
        // R11: unmapped and clear words read zero; rdata holds
        rd(10'd9, 0, "R11 unmapped reads zero");
        rd(10'd2, 0, "R11 clear word reads zero");
        rd(10'd12, 32'h3, "R11 gcfg");
        addr = 10'd0;
        repeat (3) @(negedge clk);
        check("R11 rdata holds", rdata, 32'h3);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule